// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block sends and receives characters over a pair of asynchronous serial lines at the same time. A mode byte sets the character length (5 to 8 data bits), the parity (none, odd or even), the ratio of serial clock ticks to bit time (1, 16 or 64) and the stop length (1, 1.5 or 2 bits). A command byte enables the transmitter and the receiver, holds the line in a break state and clears the sticky error flags. Each direction has a one-character holding register in front of its shift register. The host can therefore load the next character, or leave the last received character unread, while a frame is still on the line.

The serial clock enters as a single-cycle `tick` enable in the `clk` domain. The transmitter changes its line only on a tick. It sends a low start bit, then the data least significant bit first, then the optional parity bit, then the stop time. The receiver passes `rxd` through a synchronizer and checks that the line is still low at the middle of the start bit. It then samples each later bit at its middle and reports parity, framing and overrun errors. It also reports a break, which is a frame that stays low from the start bit through the stop bit.

Top module: `serial_xcvr`

## Requirements
- R1: After reset, `txd` is 1, `status` is 8'h05 (transmit ready and transmitter empty), the mode byte is 0 and all command enables are off.
- R2: The mode byte written with `wr_sel`=1 sets the frame. Bits [1:0] hold the data length minus 5, and bits [5:4] pick the bit time in ticks: 00 gives 1, 01 gives 16, 10 and 11 give 64. A frame is a low start bit, then the data least significant bit first, with every bit lasting one bit time.
- R3: Mode bits [3:2] select the parity: 01 is odd, 10 is even, 00 and 11 mean no parity. The parity bit covers only the active data bits and follows the last data bit.
- R4: Mode bits [7:6] set the high stop time after the frame: 00 lasts one bit time M, 01 lasts M plus M/2 rounded up (2 ticks at 1x), and 10 and 11 last 2M.
- R5: `status[0]` (transmit ready) is 0 only while a character waits in the holding register. When one waits, the next start bit begins on the tick that ends the previous stop time. A data write while `status[0]` is 0 is dropped. `status[2]` is 1 only when no frame is on the line and none is waiting.
- R6: A new frame starts only while command bit 0 (transmit enable) is set. A waiting character stays held until the bit is set.
- R7: While command bit 2 (break) is set, `txd` is held at 0.
- R8: The receiver delivers a character right-justified on `rx_data`, with zeros above the character length, and sets `status[1]`. A pulse on `rd_en` clears `status[1]`.
- R9: At 16x and 64x, a low on the line that is high again at the middle of the start bit (half a bit time after detection) is dropped and no character is delivered.
- R10: `status[3]` is set on a parity mismatch and `status[5]` when the stop sample is low. `status[4]` is set when a character completes while `status[1]` is still set. In that case `rx_data` takes the new character.
- R11: A frame whose every sample is 0, stop included, sets `status[6]` and `status[5]` and delivers no character. `status[6]` clears once the line is seen high again.
- R12: Writing a command with bit 3 set clears `status[3]`, `status[4]` and `status[5]`.
- R13: While command bit 1 (receive enable) is clear, no new frame is received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Serial clock enable, one `clk` cycle wide |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 transmit data, 1 mode byte, 2 command byte |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Receive data taken; clears the receive ready flag |
| txd | output | 1 | Serial transmit line, idles high |
| rxd | input | 1 | Serial receive line, asynchronous |
| rx_data | output | 8 | Last received character |
| status | output | 8 | {0, break, framing, overrun, parity, tx empty, rx ready, tx ready} |

## Verification
The assertions check these rules on every cycle:
- The transmit line is high whenever no frame is active.
- A write to a full holding register leaves its contents unchanged.
- A frame starts only while the transmitter is enabled.
- Reading clears the receive ready flag.
- Overrun is flagged when a character is delivered while the previous one is still unread.
- An error reset clears the error flags.
- The receiver stays idle while disabled, and returns to idle after a false start.
- A break delivers no data.

Only the bench scenarios can show the following:
- The exact transmit waveform for each mode combination, which the reference model follows tick by tick.
- The data values received in loopback.
- Parity and framing errors built into hand-driven frames.
- Rejection of a short glitch at 16x.
- Break detection and its clearing after the line returns high.

// File: rtl/serial_xcvr_pkg.sv
package serial_xcvr_pkg;

  localparam int CHAR_W = 8;
  localparam int IDX_W  = $clog2(CHAR_W);
  localparam int CNT_W  = 8;

  localparam logic [1:0] PAR_ODD  = 2'b01;
  localparam logic [1:0] PAR_EVEN = 2'b10;

  // ticks per bit for a multiplier code
  function automatic logic [CNT_W-1:0] bit_ticks(input logic [1:0] mult);
    case (mult)
      2'b00:   return CNT_W'(1);
      2'b01:   return CNT_W'(16);
      default: return CNT_W'(64);
    endcase
  endfunction

  // high time after the last frame bit, in ticks
  function automatic logic [CNT_W-1:0] stop_ticks(input logic [1:0] stop,
                                                  input logic [1:0] mult);
    logic [CNT_W-1:0] m;
    m = bit_ticks(mult);
    case (stop)
      2'b00:   return m;
      2'b01:   return m + ((m + CNT_W'(1)) >> 1);
      default: return m << 1;
    endcase
  endfunction

  function automatic int char_bits(input logic [1:0] len);
    return 5 + int'(len);
  endfunction

  function automatic logic par_on(input logic [1:0] par);
    return (par == PAR_ODD) || (par == PAR_EVEN);
  endfunction

  // parity over the active data bits only
  function automatic logic par_bit(input logic [CHAR_W-1:0] d,
                                   input logic [1:0] len,
                                   input logic [1:0] par);
    logic [CHAR_W-1:0] mask;
    for (int i = 0; i < CHAR_W; i++) mask[i] = (i < char_bits(len));
    return (par == PAR_ODD) ? ~(^(d & mask)) : ^(d & mask);
  endfunction

endpackage

// File: rtl/serial_xcvr_tx.sv
module serial_xcvr_tx
  import serial_xcvr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        len,
  input  logic [1:0]        par,
  input  logic [1:0]        mult,
  input  logic [1:0]        stop,
  input  logic              tx_en,
  input  logic              brk,
  input  logic              wr_stb,
  input  logic [CHAR_W-1:0] wr_data,
  output logic              txd,
  output logic              tx_ready,
  output logic              tx_empty
);

  typedef enum logic [1:0] {T_START, T_DATA, T_PAR, T_STOP} tph_e;

  logic              hold_valid;
  logic [CHAR_W-1:0] hold_data;
  logic [CHAR_W-1:0] sr;
  logic              busy;
  logic              line;
  logic              par_r;
  tph_e              ph;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        f_len, f_par, f_mult, f_stop;

  // named events
  logic bit_end;
  logic frame_done;
  logic frame_start;
  logic last_data;

  assign bit_end     = tick && busy && (cnt == '0);
  assign frame_done  = bit_end && (ph == T_STOP);
  assign frame_start = tick && hold_valid && tx_en && (!busy || frame_done);
  assign last_data   = (int'(idx) == char_bits(f_len) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
      sr         <= '0;
      busy       <= 1'b0;
      line       <= 1'b1;
      par_r      <= 1'b0;
      ph         <= T_START;
      idx        <= '0;
      cnt        <= '0;
      f_len      <= '0;
      f_par      <= '0;
      f_mult     <= '0;
      f_stop     <= '0;
    end else begin
      if (wr_stb && !hold_valid) begin
        hold_valid <= 1'b1;
        hold_data  <= wr_data;
      end
      if (frame_start) begin
        hold_valid <= 1'b0;
        busy       <= 1'b1;
        ph         <= T_START;
        line       <= 1'b0;
        cnt        <= bit_ticks(mult) - CNT_W'(1);
        sr         <= hold_data;
        par_r      <= par_bit(hold_data, len, par);
        idx        <= '0;
        f_len      <= len;
        f_par      <= par;
        f_mult     <= mult;
        f_stop     <= stop;
      end else if (frame_done) begin
        busy <= 1'b0;
        line <= 1'b1;
      end else if (tick && busy) begin
        if (cnt != '0) begin
          cnt <= cnt - CNT_W'(1);
        end else begin
          case (ph)
            T_START: begin
              ph   <= T_DATA;
              idx  <= '0;
              line <= sr[0];
              cnt  <= bit_ticks(f_mult) - CNT_W'(1);
            end
            T_DATA: begin
              if (last_data) begin
                if (par_on(f_par)) begin
                  ph   <= T_PAR;
                  line <= par_r;
                  cnt  <= bit_ticks(f_mult) - CNT_W'(1);
                end else begin
                  ph   <= T_STOP;
                  line <= 1'b1;
                  cnt  <= stop_ticks(f_stop, f_mult) - CNT_W'(1);
                end
              end else begin
                idx  <= idx + IDX_W'(1);
                line <= sr[idx + IDX_W'(1)];
                cnt  <= bit_ticks(f_mult) - CNT_W'(1);
              end
            end
            T_PAR: begin
              ph   <= T_STOP;
              line <= 1'b1;
              cnt  <= stop_ticks(f_stop, f_mult) - CNT_W'(1);
            end
            default: begin
              ph <= T_STOP;
            end
          endcase
        end
      end
    end
  end

  assign txd      = line & ~brk;
  assign tx_ready = ~hold_valid;
  assign tx_empty = ~busy & ~hold_valid;

  // R2: the line rests high outside a frame
  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line);

  // R5: a write into a full holding register is dropped
  assert_full_write_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_valid && wr_stb && !frame_start) |=> (hold_data == $past(hold_data)));

  // R6: frames begin only with the transmitter enabled
  assert_start_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_en));

endmodule

// File: rtl/serial_xcvr_rx.sv
module serial_xcvr_rx
  import serial_xcvr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        len,
  input  logic [1:0]        par,
  input  logic [1:0]        mult,
  input  logic              rx_en,
  input  logic              rxd,
  input  logic              rd_stb,
  input  logic              err_clr,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              par_err,
  output logic              ovr_err,
  output logic              frm_err,
  output logic              brk_det
);

  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_BRK} rst_e;

  rst_e              st;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [CHAR_W-1:0] sr;
  logic [CHAR_W-1:0] rx_hold;
  logic              par_s;
  logic              any_one;
  logic [1:0]        f_len, f_par, f_mult;

  // named events
  logic false_start;
  logic char_done;
  logic is_brk;
  logic deliver;
  logic last_data;

  assign false_start = tick && (st == R_START) && (cnt == '0) && rxd;
  assign char_done   = tick && (st == R_STOP) && (cnt == '0);
  assign is_brk      = char_done && !rxd && !any_one;
  assign deliver     = char_done && !is_brk;
  assign last_data   = (int'(idx) == char_bits(f_len) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= R_IDLE;
      cnt      <= '0;
      idx      <= '0;
      sr       <= '0;
      rx_hold  <= '0;
      par_s    <= 1'b0;
      any_one  <= 1'b0;
      f_len    <= '0;
      f_par    <= '0;
      f_mult   <= '0;
      rx_ready <= 1'b0;
      par_err  <= 1'b0;
      ovr_err  <= 1'b0;
      frm_err  <= 1'b0;
      brk_det  <= 1'b0;
    end else begin
      if (err_clr) begin
        par_err <= 1'b0;
        ovr_err <= 1'b0;
        frm_err <= 1'b0;
      end
      if (rd_stb) rx_ready <= 1'b0;
      if (tick) begin
        case (st)
          R_IDLE: begin
            if (rx_en && !rxd) begin
              sr      <= '0;
              any_one <= 1'b0;
              idx     <= '0;
              f_len   <= len;
              f_par   <= par;
              f_mult  <= mult;
              if (mult == 2'b00) begin
                st  <= R_DATA;
                cnt <= '0;
              end else begin
                st  <= R_START;
                cnt <= (bit_ticks(mult) >> 1) - CNT_W'(1);
              end
            end
          end
          R_START: begin
            if (cnt != '0) begin
              cnt <= cnt - CNT_W'(1);
            end else if (rxd) begin
              st <= R_IDLE;
            end else begin
              st  <= R_DATA;
              cnt <= bit_ticks(f_mult) - CNT_W'(1);
            end
          end
          R_DATA: begin
            if (cnt != '0) begin
              cnt <= cnt - CNT_W'(1);
            end else begin
              sr[idx] <= rxd;
              any_one <= any_one | rxd;
              cnt     <= bit_ticks(f_mult) - CNT_W'(1);
              if (last_data) st <= par_on(f_par) ? R_PAR : R_STOP;
              else           idx <= idx + IDX_W'(1);
            end
          end
          R_PAR: begin
            if (cnt != '0) begin
              cnt <= cnt - CNT_W'(1);
            end else begin
              par_s   <= rxd;
              any_one <= any_one | rxd;
              st      <= R_STOP;
              cnt     <= bit_ticks(f_mult) - CNT_W'(1);
            end
          end
          R_STOP: begin
            if (cnt != '0) begin
              cnt <= cnt - CNT_W'(1);
            end else if (is_brk) begin
              brk_det <= 1'b1;
              frm_err <= 1'b1;
              st      <= R_BRK;
            end else begin
              rx_hold  <= sr;
              rx_ready <= 1'b1;
              if (rx_ready && !rd_stb) ovr_err <= 1'b1;
              if (!rxd) frm_err <= 1'b1;
              if (par_on(f_par) && (par_s != par_bit(sr, f_len, f_par))) par_err <= 1'b1;
              st <= R_IDLE;
            end
          end
          R_BRK: begin
            if (rxd) begin
              brk_det <= 1'b0;
              st      <= R_IDLE;
            end
          end
          default: st <= R_IDLE;
        endcase
      end
    end
  end

  assign rx_data = rx_hold;

  // R8: a read clears the ready flag unless a character lands in that cycle
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !deliver) |=> !rx_ready);

  // R9: a rejected start returns the receiver to idle
  assert_false_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    false_start |=> (st == R_IDLE));

  // R10: a character landing on an unread one raises overrun
  assert_overrun_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver && rx_ready && !rd_stb) |=> ovr_err);

  // R11: a break frame delivers no data
  assert_break_no_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && is_brk) |=> $stable(rx_data));

  // R12: error reset clears the sticky flags when no frame completes
  assert_error_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !char_done) |=> !(par_err || ovr_err || frm_err));

  // R13: a disabled receiver stays idle
  assert_disabled_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == R_IDLE) && !rx_en) |=> (st == R_IDLE));

endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr
  import serial_xcvr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
)
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              rd_en,
  output logic              txd,
  input  logic              rxd,
  output logic [CHAR_W-1:0] rx_data,
  output logic [7:0]        status
);

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_MODE = 2'd1;
  localparam logic [1:0] SEL_CMD  = 2'd2;

  logic [CHAR_W-1:0]      mode_q;
  logic                   tx_en_q, rx_en_q, brk_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rxd_s;

  logic data_wr, cmd_wr, err_clr;
  logic tx_ready, tx_empty, rx_ready, par_err, ovr_err, frm_err, brk_det;

  assign data_wr = wr_en && (wr_sel == SEL_DATA);
  assign cmd_wr  = wr_en && (wr_sel == SEL_CMD);
  assign err_clr = cmd_wr && wr_data[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      if (wr_en && (wr_sel == SEL_MODE)) mode_q <= wr_data;
      if (cmd_wr) begin
        tx_en_q <= wr_data[0];
        rx_en_q <= wr_data[1];
        brk_q   <= wr_data[2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
  end
  assign rxd_s = sync_q[SYNC_STAGES-1];

  serial_xcvr_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .len      (mode_q[1:0]),
    .par      (mode_q[3:2]),
    .mult     (mode_q[5:4]),
    .stop     (mode_q[7:6]),
    .tx_en    (tx_en_q),
    .brk      (brk_q),
    .wr_stb   (data_wr),
    .wr_data  (wr_data),
    .txd      (txd),
    .tx_ready (tx_ready),
    .tx_empty (tx_empty)
  );

  serial_xcvr_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .len      (mode_q[1:0]),
    .par      (mode_q[3:2]),
    .mult     (mode_q[5:4]),
    .rx_en    (rx_en_q),
    .rxd      (rxd_s),
    .rd_stb   (rd_en),
    .err_clr  (err_clr),
    .rx_data  (rx_data),
    .rx_ready (rx_ready),
    .par_err  (par_err),
    .ovr_err  (ovr_err),
    .frm_err  (frm_err),
    .brk_det  (brk_det)
  );

  assign status = {1'b0, brk_det, frm_err, ovr_err, par_err, tx_empty, rx_ready, tx_ready};

  // R7: break forces the line low
  assert_break_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    brk_q |-> !txd);

endmodule

// File: tb/serial_xcvr_tb_top.sv
module serial_xcvr_tb_top;

  logic       clk = 1'b0;
  logic       rst_n, tick, wr_en, rd_en, rx_line, loop, cmp_on;
  logic [1:0] wr_sel;
  logic [7:0] wr_data;
  logic       txd, rxd;
  logic [7:0] rx_data, status;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  assign rxd = loop ? txd : rx_line;

  serial_xcvr dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .txd(txd), .rxd(rxd),
    .rx_data(rx_data), .status(status)
  );

  // tick generator: one cycle in four
  int tdiv;
  always @(negedge clk) begin
    if (!rst_n) begin tdiv <= 0; tick <= 1'b0; end
    else begin tdiv <= (tdiv == 3) ? 0 : tdiv + 1; tick <= (tdiv == 3); end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // ---------------- reference model of the transmitter ----------------
  int         lvq[$];
  logic [7:0] wq[$];
  bit         cur, in_frame;
  int         m_len, m_par, m_mult, m_stop;
  bit         m_txen, m_brk;

  function automatic void expand(input logic [7:0] d);
    int p = 0;
    int s;
    for (int k = 0; k < m_mult; k++) lvq.push_back(0);
    for (int i = 0; i < m_len; i++) begin
      for (int k = 0; k < m_mult; k++) lvq.push_back(int'(d[i]));
      p = p ^ int'(d[i]);
    end
    if (m_par == 1 || m_par == 2) begin
      if (m_par == 1) p = 1 - p;
      for (int k = 0; k < m_mult; k++) lvq.push_back(p);
    end
    if (m_stop == 0)      s = m_mult;
    else if (m_stop == 1) s = m_mult + (m_mult + 1) / 2;
    else                  s = 2 * m_mult;
    for (int k = 0; k < s; k++) lvq.push_back(1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      lvq.delete(); wq.delete();
      cur = 1; in_frame = 0;
      m_len = 5; m_par = 0; m_mult = 1; m_stop = 0; m_txen = 0; m_brk = 0;
    end else begin
      if (tick) begin
        if (lvq.size() > 0) cur = lvq.pop_front()[0];
        else if (wq.size() > 0 && m_txen) begin
          expand(wq.pop_front());
          cur = lvq.pop_front()[0];
          in_frame = 1;
        end else begin
          cur = 1; in_frame = 0;
        end
      end
      if (wr_en) begin
        if (wr_sel == 2'd0) begin
          if (wq.size() == 0) wq.push_back(wr_data);
        end else if (wr_sel == 2'd1) begin
          m_len  = 5 + int'(wr_data[1:0]);
          m_par  = int'(wr_data[3:2]);
          m_mult = (wr_data[5:4] == 2'b00) ? 1 : (wr_data[5:4] == 2'b01) ? 16 : 64;
          m_stop = int'(wr_data[7:6]);
        end else if (wr_sel == 2'd2) begin
          m_txen = wr_data[0];
          m_brk  = wr_data[2];
        end
      end
    end
  end

  // compare the transmit side on every clock
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check(m_brk ? "R7" : "R2 R3 R4", {31'd0, txd}, {31'd0, cur & ~m_brk}, "txd");
      check("R5", {31'd0, status[0]}, {31'd0, wq.size() == 0}, "tx ready");
      check("R5", {31'd0, status[2]}, {31'd0, !in_frame && wq.size() == 0}, "tx empty");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_read();
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
  endtask

  task automatic wait_tx_done();
    @(negedge clk);
    while (!status[2]) @(negedge clk);
    wait_ticks(6);
    @(negedge clk);
  endtask

  task automatic drive_level(input logic v, input int n);
    @(negedge clk); rx_line = v;
    wait_ticks(n);
  endtask

  task automatic drive_frame(input logic [7:0] d, input int len, input int m,
                             input bit use_par, input bit pval, input bit stopv);
    drive_level(1'b0, m);
    for (int i = 0; i < len; i++) drive_level(d[i], m);
    if (use_par) drive_level(pval, m);
    drive_level(stopv, m);
    drive_level(1'b1, 2 * m);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 0; wr_en = 0; rd_en = 0; wr_sel = 0; wr_data = 0;
    rx_line = 1; loop = 1; cmp_on = 0;
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1", {31'd0, txd}, 32'd1, "txd after reset");
    check("R1", {24'd0, status}, 32'h05, "status after reset");
    cmp_on = 1;

    // 8 data bits, no parity, 16x, one stop, loopback
    do_write(2'd1, 8'h13);
    do_write(2'd2, 8'h03);
    do_write(2'd0, 8'hA5);
    wait_tx_done();
    check("R8", {31'd0, status[1]}, 32'd1, "rx ready 8N1");
    check("R2", {24'd0, rx_data}, 32'hA5, "rx data 8N1");
    do_read();
    check("R8", {31'd0, status[1]}, 32'd0, "rx ready after read");

    // 5 bits, even parity, 1x, two stops
    do_write(2'd1, 8'h88);
    do_write(2'd0, 8'hFF);
    wait_tx_done();
    check("R8", {24'd0, rx_data}, 32'h1F, "5-bit data right-justified");
    check("R3", {31'd0, status[3]}, 32'd0, "even parity loopback");
    check("R4", {31'd0, status[5]}, 32'd0, "two stops framing");
    do_read();

    // 7 bits, odd parity, 64x, 1.5 stops
    do_write(2'd1, 8'h66);
    do_write(2'd0, 8'hDA);
    wait_tx_done();
    check("R3", {24'd0, rx_data}, 32'h5A, "7-bit odd data");
    check("R3", {31'd0, status[3]}, 32'd0, "odd parity loopback");
    check("R4", {31'd0, status[5]}, 32'd0, "1.5 stops framing");
    do_read();

    // back-to-back characters, dropped write, overrun
    do_write(2'd1, 8'h13);
    do_write(2'd0, 8'h3C);
    @(negedge clk);
    while (!status[0]) @(negedge clk);
    do_write(2'd0, 8'hC3);
    check("R5", {31'd0, status[0]}, 32'd0, "holding full");
    do_write(2'd0, 8'h99);
    wait_tx_done();
    wait_ticks(40);
    @(negedge clk);
    check("R10", {31'd0, status[4]}, 32'd1, "overrun flag");
    check("R10", {24'd0, rx_data}, 32'hC3, "overrun keeps newest");
    check("R5", {24'd0, rx_data}, 32'hC3, "dropped write never sent");
    do_write(2'd2, 8'h0B);
    @(negedge clk);
    check("R12", {29'd0, status[5:3]}, 32'd0, "error reset after overrun");
    do_read();

    // hand-driven frames: 8 bits even parity 16x
    loop = 1'b0;
    do_write(2'd1, 8'h1B);
    drive_frame(8'h0F, 8, 16, 1'b1, 1'b1, 1'b1);
    wait_ticks(4); @(negedge clk);
    check("R10", {31'd0, status[3]}, 32'd1, "parity error");
    check("R10", {31'd0, status[5]}, 32'd0, "no framing error");
    check("R8", {24'd0, rx_data}, 32'h0F, "data with parity error");
    do_write(2'd2, 8'h0B);
    do_read();
    drive_frame(8'h81, 8, 16, 1'b1, 1'b0, 1'b0);
    wait_ticks(4); @(negedge clk);
    check("R10", {31'd0, status[5]}, 32'd1, "framing error");
    check("R8", {24'd0, rx_data}, 32'h81, "data with framing error");
    do_write(2'd2, 8'h0B);
    @(negedge clk);
    check("R12", {29'd0, status[5:3]}, 32'd0, "error reset after framing");
    do_read();

    // false start then a valid frame
    drive_level(1'b0, 3);
    drive_level(1'b1, 24);
    @(negedge clk);
    check("R9", {31'd0, status[1]}, 32'd0, "glitch rejected");
    drive_frame(8'h42, 8, 16, 1'b1, 1'b0, 1'b1);
    wait_ticks(4); @(negedge clk);
    check("R9", {24'd0, rx_data}, 32'h42, "frame after glitch");
    do_read();

    // receiver disabled
    do_write(2'd2, 8'h01);
    drive_frame(8'h77, 8, 16, 1'b1, 1'b0, 1'b1);
    wait_ticks(4); @(negedge clk);
    check("R13", {31'd0, status[1]}, 32'd0, "disabled receiver");
    check("R13", {24'd0, rx_data}, 32'h42, "data unchanged when disabled");
    do_write(2'd2, 8'h03);

    // break in loopback
    loop = 1'b1;
    do_write(2'd2, 8'h07);
    wait_ticks(220); @(negedge clk);
    check("R11", {31'd0, status[6]}, 32'd1, "break detected");
    check("R11", {31'd0, status[5]}, 32'd1, "break framing flag");
    check("R11", {31'd0, status[1]}, 32'd0, "break delivers nothing");
    check("R7", {31'd0, txd}, 32'd0, "line low in break");
    do_write(2'd2, 8'h03);
    wait_ticks(10); @(negedge clk);
    check("R11", {31'd0, status[6]}, 32'd0, "break cleared on high line");
    do_write(2'd2, 8'h0B);
    @(negedge clk);
    check("R12", {31'd0, status[5]}, 32'd0, "error reset after break");

    // transmitter disabled holds the character
    do_write(2'd2, 8'h02);
    do_write(2'd0, 8'h55);
    wait_ticks(100); @(negedge clk);
    check("R6", {31'd0, txd}, 32'd1, "no frame while disabled");
    check("R6", {31'd0, status[0]}, 32'd0, "character held");
    do_write(2'd2, 8'h03);
    wait_tx_done();
    check("R6", {24'd0, rx_data}, 32'h55, "held character sent on enable");
    check("R6", {31'd0, status[3]}, 32'd0, "held character parity");

    finish_run();
  end

endmodule